// File: doc/BRIEF.md
# Receive Interrupt Threshold Coalescer

This block decides when a network receive path should interrupt its host. It watches three values: the number of frames waiting in the receive queue, the number of bytes those frames occupy, and how long the queue has held data, counted in 1 µs ticks. Each value has its own programmable limit and its own enable. When an enabled value goes above its limit, a level-type hit flag rises and the host can read it.

The three hits feed one sticky receive-interrupt status bit. The host clears that bit by writing a one to it. The status reaches the interrupt pin only while the receive interrupt enable is set. Upstream logic supplies a frame-arrival pulse with the frame's length, a dequeue pulse with the length of the frame removed, and a free-running 1 µs tick. The queue memory and the register decoding are outside this block.

Top module: `rxirq_coalescer`

## Requirements
- R1: `frame_cnt` goes up by one on an arrival and down by one on a dequeue. It stays the same when both occur in one cycle, it saturates at 255, and a dequeue while the count is zero is ignored. Changes show after the next rising clock edge.
- R2: `byte_cnt` adds `arr_len` on an arrival and subtracts `deq_len` on an accepted dequeue. It never goes below zero and saturates at 65535. A dequeue while the queue is empty leaves it unchanged.
- R3: `dwell_time` increments on each cycle with `tick_1us` high while `frame_cnt` is non-zero, and saturates at 65535. It returns to zero on the same edge at which `frame_cnt` becomes zero.
- R4: `fcnt_hit` is high in the same cycle exactly when `fcnt_en` is 1 and `frame_cnt` is strictly greater than `fcnt_thr`.
- R5: `bcnt_hit` is high in the same cycle exactly when `bcnt_en` is 1 and `byte_cnt` is strictly greater than `bcnt_thr`.
- R6: `time_hit` is high in the same cycle exactly when `time_en` is 1 and `dwell_time` is strictly greater than `time_thr`.
- R7: If any hit flag is high in a cycle, `irq_status` is 1 after the next rising edge. It then stays 1 until it is cleared.
- R8: A cycle with `irq_clr` high clears `irq_status` at the next edge, unless a hit is present in that same cycle. In that case the bit stays 1.
- R9: `irq` equals `irq_status` AND `irq_en`. With `irq_en` at 0, the status bit still records hits.
- R10: After reset, all counters, hit flags, `irq_status` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_valid | input | 1 | One-cycle pulse: a frame has entered the queue |
| arr_len | input | 11 | Byte length of the arriving frame |
| deq_valid | input | 1 | One-cycle pulse: a frame has left the queue |
| deq_len | input | 11 | Byte length of the departing frame |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| fcnt_en | input | 1 | Enable for the frame-count limit |
| fcnt_thr | input | 8 | Frame-count limit |
| bcnt_en | input | 1 | Enable for the byte-count limit |
| bcnt_thr | input | 16 | Byte-count limit |
| time_en | input | 1 | Enable for the dwell-time limit |
| time_thr | input | 16 | Dwell-time limit in microseconds |
| irq_en | input | 1 | Receive interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| frame_cnt | output | 8 | Frames currently queued |
| byte_cnt | output | 16 | Bytes currently queued |
| dwell_time | output | 16 | Microseconds the queue has been non-empty |
| fcnt_hit | output | 1 | Frame-count limit exceeded |
| bcnt_hit | output | 1 | Byte-count limit exceeded |
| time_hit | output | 1 | Dwell-time limit exceeded |
| irq_status | output | 1 | Sticky receive interrupt status |
| irq | output | 1 | Interrupt request to the host |

## Verification
The bound checker tests relations on every cycle:
- the frame count steps up on a lone arrival;
- the dwell timer is zero whenever the queue is empty;
- a time hit never appears with a zero timer;
- any hit latches the status bit;
- a clear with no hit drops the status bit;
- the interrupt pin is never high without both status and enable.

Other behaviours need the bench's scenarios to show:
- the saturation points of each counter;
- the strict greater-than boundary of each limit;
- a dequeue on an empty queue being ignored;
- set winning over a simultaneous clear.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  typedef struct packed {
    logic frames;
    logic bytes;
    logic dwell;
  } rxc_hits_t;

  // Largest value a w-bit unsigned counter can hold, in 32 bits.
  function automatic logic [31:0] cap_of(input int w);
    logic [32:0] one_sh;
    one_sh = 33'd1 << w;
    return (w >= 32) ? 32'hFFFF_FFFF : (one_sh[31:0] - 32'd1);
  endfunction

  // cur + add - sub, clamped to [0, lim].
  function automatic logic [31:0] sat_step(input logic [31:0] cur,
                                           input logic [31:0] add,
                                           input logic [31:0] sub,
                                           input logic [31:0] lim);
    logic [32:0] acc;
    acc = {1'b0, cur} + {1'b0, add};
    if (acc < {1'b0, sub}) acc = 33'd0;
    else                   acc = acc - {1'b0, sub};
    if (acc > {1'b0, lim}) acc = {1'b0, lim};
    return acc[31:0];
  endfunction

  // Strict comparison gated by the enable.
  function automatic logic over_limit(input logic en,
                                      input logic [31:0] val,
                                      input logic [31:0] lim);
    return en && (val > lim);
  endfunction

endpackage

// File: rtl/rxc_occupancy.sv
module rxc_occupancy #(
  parameter int FW = 8,
  parameter int BW = 16,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arr_valid,
  input  logic [LW-1:0] arr_len,
  input  logic          deq_valid,
  input  logic [LW-1:0] deq_len,
  output logic [FW-1:0] frame_q,
  output logic [BW-1:0] byte_q,
  output logic          deq_ok,
  output logic          empty_nxt
);
  import rxc_pkg::*;

  localparam logic [31:0] FCAP = cap_of(FW);
  localparam logic [31:0] BCAP = cap_of(BW);

  logic [31:0] frame_d32;
  logic [31:0] byte_d32;

  assign deq_ok = deq_valid && (frame_q != '0);

  always_comb begin
    frame_d32 = sat_step(32'(frame_q), {31'd0, arr_valid}, {31'd0, deq_ok}, FCAP);
    byte_d32  = sat_step(32'(byte_q),
                         arr_valid ? 32'(arr_len) : 32'd0,
                         deq_ok    ? 32'(deq_len) : 32'd0,
                         BCAP);
  end

  assign empty_nxt = (frame_d32 == 32'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      byte_q  <= '0;
    end else begin
      frame_q <= frame_d32[FW-1:0];
      byte_q  <= byte_d32[BW-1:0];
    end
  end

endmodule

// File: rtl/rxc_dwell.sv
module rxc_dwell #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          occupied,
  input  logic          empty_nxt,
  output logic [TW-1:0] dwell_q,
  output logic          dwell_step
);
  import rxc_pkg::*;

  localparam logic [31:0] TCAP = cap_of(TW);

  logic [31:0] dwell_d32;

  assign dwell_step = tick && occupied;

  always_comb begin
    if (empty_nxt) dwell_d32 = 32'd0;
    else           dwell_d32 = sat_step(32'(dwell_q), {31'd0, dwell_step}, 32'd0, TCAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dwell_q <= '0;
    else        dwell_q <= dwell_d32[TW-1:0];
  end

endmodule

// File: rtl/rxc_limit.sv
module rxc_limit #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] val,
  input  logic [W-1:0] lim,
  output logic         hit
);
  import rxc_pkg::*;

  assign hit = over_limit(en, 32'(val), 32'(lim));

endmodule

// File: rtl/rxc_irq.sv
module rxc_irq (
  input  logic               clk,
  input  logic               rst_n,
  input  rxc_pkg::rxc_hits_t hits,
  input  logic               clr,
  input  logic               en,
  output logic               any_hit,
  output logic               status_q,
  output logic               irq
);

  assign any_hit = |hits;

  // A hit in the same cycle as a clear keeps the bit set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= any_hit | (status_q & ~clr);
  end

  assign irq = status_q & en;

endmodule

// File: rtl/rxirq_coalescer.sv
module rxirq_coalescer #(
  parameter int FCNT_W = 8,
  parameter int BCNT_W = 16,
  parameter int TIME_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_valid,
  input  logic [LEN_W-1:0]  arr_len,
  input  logic              deq_valid,
  input  logic [LEN_W-1:0]  deq_len,
  input  logic              tick_1us,
  input  logic              fcnt_en,
  input  logic [FCNT_W-1:0] fcnt_thr,
  input  logic              bcnt_en,
  input  logic [BCNT_W-1:0] bcnt_thr,
  input  logic              time_en,
  input  logic [TIME_W-1:0] time_thr,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic [FCNT_W-1:0] frame_cnt,
  output logic [BCNT_W-1:0] byte_cnt,
  output logic [TIME_W-1:0] dwell_time,
  output logic              fcnt_hit,
  output logic              bcnt_hit,
  output logic              time_hit,
  output logic              irq_status,
  output logic              irq
);
  import rxc_pkg::*;

  // Internal events, named so that the checker can see them.
  logic      deq_ok;
  logic      empty_nxt;
  logic      dwell_step;
  logic      any_hit;
  rxc_hits_t hits;

  rxc_occupancy #(.FW(FCNT_W), .BW(BCNT_W), .LW(LEN_W)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_valid (arr_valid),
    .arr_len   (arr_len),
    .deq_valid (deq_valid),
    .deq_len   (deq_len),
    .frame_q   (frame_cnt),
    .byte_q    (byte_cnt),
    .deq_ok    (deq_ok),
    .empty_nxt (empty_nxt)
  );

  rxc_dwell #(.TW(TIME_W)) u_dwell (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_1us),
    .occupied   (frame_cnt != '0),
    .empty_nxt  (empty_nxt),
    .dwell_q    (dwell_time),
    .dwell_step (dwell_step)
  );

  rxc_limit #(.W(FCNT_W)) u_lim_frames (.en(fcnt_en), .val(frame_cnt),  .lim(fcnt_thr), .hit(fcnt_hit));
  rxc_limit #(.W(BCNT_W)) u_lim_bytes  (.en(bcnt_en), .val(byte_cnt),   .lim(bcnt_thr), .hit(bcnt_hit));
  rxc_limit #(.W(TIME_W)) u_lim_dwell  (.en(time_en), .val(dwell_time), .lim(time_thr), .hit(time_hit));

  assign hits = '{frames: fcnt_hit, bytes: bcnt_hit, dwell: time_hit};

  rxc_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hits     (hits),
    .clr      (irq_clr),
    .en       (irq_en),
    .any_hit  (any_hit),
    .status_q (irq_status),
    .irq      (irq)
  );

endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
  parameter int FW = 8,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arr_valid,
  input logic          deq_valid,
  input logic [FW-1:0] frame_cnt,
  input logic [TW-1:0] dwell_time,
  input logic          time_hit,
  input logic          any_hit,
  input logic          irq_clr,
  input logic          irq_en,
  input logic          irq_status,
  input logic          irq
);

  // R1
  frame_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !deq_valid && frame_cnt != '1) |=> (frame_cnt == $past(frame_cnt) + FW'(1)));

  // R3
  dwell_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_cnt == '0) |-> (dwell_time == '0));

  // R6
  time_hit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_hit |-> (dwell_time != '0));

  // R7
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> irq_status);

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !any_hit) |=> !irq_status);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_status && irq_en));

endmodule

bind rxirq_coalescer rxc_checker #(.FW(FCNT_W), .TW(TIME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arr_valid  (arr_valid),
  .deq_valid  (deq_valid),
  .frame_cnt  (frame_cnt),
  .dwell_time (dwell_time),
  .time_hit   (time_hit),
  .any_hit    (any_hit),
  .irq_clr    (irq_clr),
  .irq_en     (irq_en),
  .irq_status (irq_status),
  .irq        (irq)
);

// File: tb/sim_rxirq_coalescer.sv
module sim_rxirq_coalescer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arr_valid = 1'b0;
  logic [10:0] arr_len = '0;
  logic        deq_valid = 1'b0;
  logic [10:0] deq_len = '0;
  logic        tick_1us = 1'b0;
  logic        fcnt_en = 1'b0;
  logic [7:0]  fcnt_thr = '0;
  logic        bcnt_en = 1'b0;
  logic [15:0] bcnt_thr = '0;
  logic        time_en = 1'b0;
  logic [15:0] time_thr = '0;
  logic        irq_en = 1'b0;
  logic        irq_clr = 1'b0;
  logic [7:0]  frame_cnt;
  logic [15:0] byte_cnt;
  logic [15:0] dwell_time;
  logic        fcnt_hit, bcnt_hit, time_hit, irq_status, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rxirq_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_len(arr_len),
    .deq_valid(deq_valid), .deq_len(deq_len), .tick_1us(tick_1us),
    .fcnt_en(fcnt_en), .fcnt_thr(fcnt_thr), .bcnt_en(bcnt_en), .bcnt_thr(bcnt_thr),
    .time_en(time_en), .time_thr(time_thr), .irq_en(irq_en), .irq_clr(irq_clr),
    .frame_cnt(frame_cnt), .byte_cnt(byte_cnt), .dwell_time(dwell_time),
    .fcnt_hit(fcnt_hit), .bcnt_hit(bcnt_hit), .time_hit(time_hit),
    .irq_status(irq_status), .irq(irq)
  );

  typedef struct packed {
    logic        a;
    logic [10:0] al;
    logic        d;
    logic [10:0] dl;
    logic [7:0]  efc;
    logic [15:0] ebc;
  } vec_t;

  // Occupancy steps from an empty queue (R1, R2).
  localparam vec_t VECS [8] = '{
    '{1'b1, 11'd100,  1'b0, 11'd0,    8'd1, 16'd100},
    '{1'b1, 11'd60,   1'b0, 11'd0,    8'd2, 16'd160},
    '{1'b1, 11'd40,   1'b1, 11'd100,  8'd2, 16'd100},
    '{1'b0, 11'd0,    1'b1, 11'd60,   8'd1, 16'd40},
    '{1'b0, 11'd0,    1'b1, 11'd50,   8'd0, 16'd0},
    '{1'b0, 11'd0,    1'b1, 11'd10,   8'd0, 16'd0},
    '{1'b1, 11'd2000, 1'b0, 11'd0,    8'd1, 16'd2000},
    '{1'b0, 11'd0,    1'b1, 11'd2000, 8'd0, 16'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of events; outputs are sampled 2 ns after the edge.
  task automatic step(input logic a, input int al, input logic d, input int dl,
                      input logic t, input logic c);
    @(negedge clk);
    arr_valid = a; arr_len = 11'(al);
    deq_valid = d; deq_len = 11'(dl);
    tick_1us = t;  irq_clr = c;
    @(posedge clk);
    #2;
    arr_valid = 1'b0; deq_valid = 1'b0; tick_1us = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 0, 1'b0, 0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fcnt_en = 1'b0; bcnt_en = 1'b0; time_en = 1'b0; irq_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    // R10: reset state
    chk("R10 frame_cnt", int'(frame_cnt), 0);
    chk("R10 byte_cnt", int'(byte_cnt), 0);
    chk("R10 dwell_time", int'(dwell_time), 0);
    chk("R10 irq_status", int'(irq_status), 0);
    chk("R10 irq", int'(irq), 0);
    chk("R10 hits", int'({fcnt_hit, bcnt_hit, time_hit}), 0);
    do_reset();

    // Vector table walk: R1 and R2
    foreach (VECS[i]) begin
      step(VECS[i].a, int'(VECS[i].al), VECS[i].d, int'(VECS[i].dl), 1'b0, 1'b0);
      chk("R1 vector frame_cnt", int'(frame_cnt), int'(VECS[i].efc));
      chk("R2 vector byte_cnt", int'(byte_cnt), int'(VECS[i].ebc));
    end

    // R1 saturation at 255, R2 keeps adding
    for (int k = 0; k < 260; k++) step(1'b1, 1, 1'b0, 0, 1'b0, 1'b0);
    chk("R1 saturate", int'(frame_cnt), 255);
    chk("R2 sum", int'(byte_cnt), 260);
    // R4 strict boundary
    @(negedge clk); fcnt_en = 1'b1; fcnt_thr = 8'd254; #1;
    chk("R4 above limit", int'(fcnt_hit), 1);
    @(negedge clk); fcnt_thr = 8'd255; #1;
    chk("R4 equal to limit", int'(fcnt_hit), 0);
    @(negedge clk); fcnt_en = 1'b0; fcnt_thr = 8'd0; #1;
    chk("R4 disabled", int'(fcnt_hit), 0);
    // R2 saturation at 65535
    for (int k = 0; k < 40; k++) step(1'b1, 2000, 1'b0, 0, 1'b0, 1'b0);
    chk("R2 saturate", int'(byte_cnt), 65535);
    chk("R1 still saturated", int'(frame_cnt), 255);
    // R5 boundary
    @(negedge clk); bcnt_en = 1'b1; bcnt_thr = 16'd65534; #1;
    chk("R5 above limit", int'(bcnt_hit), 1);
    @(negedge clk); bcnt_thr = 16'd65535; #1;
    chk("R5 equal to limit", int'(bcnt_hit), 0);
    @(negedge clk); bcnt_en = 1'b0; #1;
    // Drain: R2 floor
    for (int k = 0; k < 255; k++) step(1'b0, 0, 1'b1, 2000, 1'b0, 1'b0);
    chk("R1 drained", int'(frame_cnt), 0);
    chk("R2 floor at zero", int'(byte_cnt), 0);

    // R3 dwell timer
    do_reset();
    step(1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    chk("R3 no count when empty", int'(dwell_time), 0);
    step(1'b1, 64, 1'b0, 0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    idle();
    chk("R3 five ticks", int'(dwell_time), 5);
    // R6 boundary
    @(negedge clk); time_en = 1'b1; time_thr = 16'd4; #1;
    chk("R6 above limit", int'(time_hit), 1);
    @(negedge clk); time_thr = 16'd5; #1;
    chk("R6 equal to limit", int'(time_hit), 0);
    @(negedge clk); time_en = 1'b0; #1;
    step(1'b0, 0, 1'b1, 64, 1'b1, 1'b0);
    chk("R3 zero on empty", int'(dwell_time), 0);
    // R3 saturation
    step(1'b1, 8, 1'b0, 0, 1'b0, 1'b0);
    @(negedge clk); tick_1us = 1'b1;
    repeat (65540) @(posedge clk);
    #2; tick_1us = 1'b0;
    chk("R3 saturate", int'(dwell_time), 65535);

    // R7, R8, R9: interrupt status
    do_reset();
    step(1'b1, 10, 1'b0, 0, 1'b0, 1'b0);
    step(1'b1, 10, 1'b0, 0, 1'b0, 1'b0);
    chk("R7 no hit no status", int'(irq_status), 0);
    @(negedge clk); fcnt_en = 1'b1; fcnt_thr = 8'd1;
    @(posedge clk); #2;
    chk("R7 status set", int'(irq_status), 1);
    chk("R9 masked", int'(irq), 0);
    @(negedge clk); irq_en = 1'b1; #1;
    chk("R9 enabled", int'(irq), 1);
    step(1'b0, 0, 1'b0, 0, 1'b0, 1'b1);
    chk("R8 set wins over clear", int'(irq_status), 1);
    @(negedge clk); fcnt_en = 1'b0;
    @(posedge clk); #2;
    chk("R7 sticky after hit ends", int'(irq_status), 1);
    step(1'b0, 0, 1'b0, 0, 1'b0, 1'b1);
    chk("R8 cleared", int'(irq_status), 0);
    chk("R9 irq low after clear", int'(irq), 0);
    // Byte hit also drives status (R5, R7)
    @(negedge clk); bcnt_en = 1'b1; bcnt_thr = 16'd19;
    @(posedge clk); #2;
    chk("R7 status from byte hit", int'(irq_status), 1);

    finish_run();
  end

endmodule